// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block decides which parts of a small microcontroller receive a clock. Software writes an oscillator-control register that holds a CPU-idle enable bit and a two-bit clock-source select. From that register the block drives a source select for a glitch-free clock mux, a CPU clock enable and a peripheral clock enable. It also reports which oscillator is currently driving the mux.

A one-cycle sleep-request pulse stands for execution of a sleep instruction. It moves the block out of Run and into one of two states:
- Idle, when the idle-enable bit is set: the CPU clock stops and the peripherals keep running.
- Sleep, when the idle-enable bit is clear: every clock stops.

A wake pulse brings the block back to Run on the source the register currently selects. Changing only the source field while in Run moves the device to a different Run variant. No sleep request is needed for that.

Each oscillator has a ready input. The block never hands the mux a source that is not yet running. A requested switch leaves the previous source in place until the new one reports ready. The oscillators themselves, their start-up circuits and the wake-source logic sit outside this block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0x00, the primary source is active (src_sel = 00, src_active = 001), mode is Run (mode = 00), and both clock enables are 1.
- R2: Writes affect only register bit 7 (idle enable) and bits 1:0 (source field). All other bits read as 0. The register keeps its value when no write occurs.
- R3: The source field is decoded as 00 = primary, 01 = secondary, 1x = internal. src_sel reports the active source as 00, 01 or 10. src_active is one-hot, with bit 0 = primary, bit 1 = secondary and bit 2 = internal.
- R4: The active source changes to the requested source on the first clock edge at which the requested source's ready input is high. That edge is one cycle after the register write at the earliest. While the ready input is low, the previous source stays active.
- R5: A sleep request in Run with the idle-enable bit at 1 enters Idle on the next edge: mode = 01, CPU enable = 0, peripheral enable = 1.
- R6: A sleep request in Run with the idle-enable bit at 0 enters Sleep on the next edge: mode = 10, and both enables = 0.
- R7: A wake pulse in Idle returns the block to Run on the next edge, with both enables at 1.
- R8: A wake pulse in Sleep starts a wait that still reports mode 10. The block returns to Run, with both enables at 1, on the first later edge at which the selected source's ready input is high. The active source at that point is the selected one.
- R9: A sleep request outside Run has no effect. A wake pulse in Run has no effect.
- R10: Source switching is frozen in Sleep, so src_sel does not change even if a ready new source is requested. In Idle, a source switch proceeds as it does in Run.
- R11: Both enables come straight from flops and change only together with the mode. The CPU enable is never 1 while the peripheral enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| sleep_req | input | 1 | One-cycle sleep request |
| wake | input | 1 | One-cycle wake event |
| src_ready | input | 3 | Per-source running flags (bit 0 primary, bit 1 secondary, bit 2 internal) |
| src_sel | output | 2 | Source code for the clock mux |
| src_active | output | 3 | One-hot active-source status |
| mode | output | 2 | 00 Run, 01 Idle, 10 Sleep |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |

## Verification
The bench builds the block with its default parameters: an 8-bit register, idle enable at bit 7 and the source field at bits 1:0. With that small configuration, a full sweep is within reach:
- The source-switch sweep covers every pair of starting and requested source codes against all eight ready-input patterns.
- The mode sweep combines each idle-enable value, each of the four source codes, and a ready or not-ready target at wake.

Directed sequences add the ignored pulses, the source freeze during Sleep and a source switch during Idle.

// File: rtl/pwr_mode_pkg.sv
// Shared types for the power-managed mode controller.
// Assumes exactly three clock sources in the order primary, secondary, internal.
package pwr_mode_pkg;

    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_SEC = 2'd1,
        SRC_INT = 2'd2
    } src_t;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_WAKING = 2'd3
    } state_t;

    // Map the two-bit register field onto a source: 00 primary, 01 secondary, 1x internal.
    function automatic src_t decode_src(input logic [1:0] code);
        if (code[1])
            return SRC_INT;
        else if (code[0])
            return SRC_SEC;
        else
            return SRC_PRI;
    endfunction

endpackage

// File: rtl/osc_ctrl_reg.sv
// Oscillator-control register. Only the idle-enable bit and the two-bit
// source field are implemented; every other bit reads as zero.
// Assumes the idle bit and the source field do not overlap.
module osc_ctrl_reg #(
    parameter int REG_W    = 8,
    parameter int IDLE_BIT = 7,
    parameter int SEL_LSB  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             idle_en,
    output logic [1:0]       sel_code
);

    localparam logic [REG_W-1:0] IDLE_MASK = REG_W'(1) << IDLE_BIT;
    localparam logic [REG_W-1:0] SEL_MASK  = REG_W'(3) << SEL_LSB;
    localparam logic [REG_W-1:0] WR_MASK   = IDLE_MASK | SEL_MASK;

    logic [REG_W-1:0] ctrl_q;

    // Capture writes to the implemented bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wdata & WR_MASK;
    end

    // Expose the fields to the rest of the block.
    always_comb begin
        rdata    = ctrl_q;
        idle_en  = ctrl_q[IDLE_BIT];
        sel_code = ctrl_q[SEL_LSB +: 2];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata == ($past(wdata) & WR_MASK))); // R2
    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rdata)); // R2

endmodule

// File: rtl/src_switch.sv
// Active clock-source tracker. It moves to the requested source only when
// that source reports ready, and it holds its choice while frozen (Sleep).
// Assumes ready inputs are already synchronous to clk.
module src_switch
    import pwr_mode_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  src_t             req_src,
    input  logic [N_SRC-1:0] src_ready,
    input  logic             freeze,
    output src_t             active,
    output logic [N_SRC-1:0] active_oh
);

    src_t active_q;
    logic req_ready;

    // Ready flag of the source the register asks for.
    always_comb req_ready = src_ready[req_src];

    // Take the requested source once it runs, unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= SRC_PRI;
        else if (!freeze && (active_q != req_src) && req_ready)
            active_q <= req_src;
    end

    always_comb active = active_q;

    // One status bit per source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_oh
        assign active_oh[g] = (active_q == src_t'(g));
    end

    AST_SWITCH_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (active != req_src && !req_ready) |=> $stable(active)); // R4
    AST_SWITCH_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && req_ready) |=> (active == $past(req_src))); // R4
    AST_FROZEN_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(active)); // R10
    AST_ACTIVE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(active_oh) == 1); // R3

endmodule

// File: rtl/mode_fsm.sv
// Run/Idle/Sleep state machine with registered clock enables.
// Sleep exits through a wait state that holds until the target source is ready.
// Assumes sleep_req and wake are single-cycle pulses synchronous to clk.
module mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sleep_req,
    input  logic   wake,
    input  logic   idle_en,
    input  logic   tgt_ready,
    output state_t state,
    output logic   cpu_en,
    output logic   per_en
);

    state_t state_q, state_d;
    logic   cpu_en_q, per_en_q;

    // Next-state decision for each mode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (sleep_req) state_d = idle_en ? ST_IDLE : ST_SLEEP;
            ST_IDLE:   if (wake)      state_d = ST_RUN;
            ST_SLEEP:  if (wake)      state_d = ST_WAKING;
            ST_WAKING: if (tgt_ready) state_d = ST_RUN;
            default:                  state_d = ST_RUN;
        endcase
    end

    // State and enables switch on the same edge, straight from flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            cpu_en_q <= 1'b1;
            per_en_q <= 1'b1;
        end else begin
            state_q  <= state_d;
            cpu_en_q <= (state_d == ST_RUN);
            per_en_q <= (state_d == ST_RUN) || (state_d == ST_IDLE);
        end
    end

    always_comb begin
        state  = state_q;
        cpu_en = cpu_en_q;
        per_en = per_en_q;
    end

    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && idle_en) |=> (state == ST_IDLE && !cpu_en && per_en)); // R5
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && !idle_en) |=> (state == ST_SLEEP && !cpu_en && !per_en)); // R6
    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wake) |=> (state == ST_RUN && cpu_en && per_en)); // R7
    AST_WAKE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKING && !tgt_ready) |=> (state == ST_WAKING && !per_en)); // R8
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !sleep_req) |=> (state == ST_RUN)); // R9
    AST_CPU_NEEDS_PER: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> per_en); // R11

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Top of the power-managed mode controller. It joins the control register,
// the source tracker and the mode machine, and it drives the mux select,
// the enables and the status outputs.
// Assumes all inputs are synchronous to clk; the clock mux itself is outside this block.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int IDLE_BIT = 7,
    parameter int SEL_LSB  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sleep_req,
    input  logic             wake,
    input  logic [2:0]       src_ready,
    output logic [1:0]       src_sel,
    output logic [2:0]       src_active,
    output logic [1:0]       mode,
    output logic             cpu_clk_en,
    output logic             per_clk_en
);

    logic       idle_en;
    logic [1:0] sel_code;
    src_t       req_src, active;
    state_t     state;
    logic       tgt_ready;
    logic       freeze;

    osc_ctrl_reg #(
        .REG_W   (REG_W),
        .IDLE_BIT(IDLE_BIT),
        .SEL_LSB (SEL_LSB)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .idle_en (idle_en),
        .sel_code(sel_code)
    );

    // Requested source, its ready flag, and the freeze during full Sleep.
    always_comb begin
        req_src   = decode_src(sel_code);
        tgt_ready = src_ready[req_src];
        freeze    = (state == ST_SLEEP);
    end

    src_switch #(
        .N_SRC(NUM_SRC)
    ) u_switch (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_src  (req_src),
        .src_ready(src_ready),
        .freeze   (freeze),
        .active   (active),
        .active_oh(src_active)
    );

    mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_req(sleep_req),
        .wake     (wake),
        .idle_en  (idle_en),
        .tgt_ready(tgt_ready),
        .state    (state),
        .cpu_en   (cpu_clk_en),
        .per_en   (per_clk_en)
    );

    // Status encodings for the mux and the mode output.
    always_comb begin
        src_sel = active;
        unique case (state)
            ST_RUN:  mode = 2'b00;
            ST_IDLE: mode = 2'b01;
            default: mode = 2'b10;
        endcase
    end

    AST_RUN_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKING && tgt_ready) |=> (src_sel == $past(req_src))); // R8
    AST_ENABLES_TRACK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode) |-> ($stable(cpu_clk_en) && $stable(per_clk_en))); // R11

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sleep_req = 1'b0;
    logic       wake = 1'b0;
    logic [2:0] src_ready = 3'b111;
    logic [1:0] src_sel;
    logic [2:0] src_active;
    logic [1:0] mode;
    logic       cpu_clk_en, per_clk_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_ctrl u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_req(sleep_req), .wake(wake),
        .src_ready(src_ready), .src_sel(src_sel), .src_active(src_active),
        .mode(mode), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr_en = 1'b1;
        reg_wdata = v;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake = 1'b1; tick(); wake = 1'b0;
    endtask

    function automatic int dec(input int code);
        return (code >= 2) ? 2 : code;
    endfunction

    task automatic chk_run(input string req);
        chk(req, "mode", mode, 0);
        chk(req, "cpu_en", cpu_clk_en, 1);
        chk(req, "per_en", per_clk_en, 1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1", "rdata", reg_rdata, 0);
        chk("R1", "src_sel", src_sel, 0);
        chk("R1", "src_active", src_active, 1);
        chk_run("R1");

        // R2 unimplemented bits read zero
        for (int v = 0; v < 256; v += 37) begin
            wr(8'(v));
            chk("R2", "rdata", reg_rdata, v & 8'h83);
            tick();
            chk("R2", "rdata held", reg_rdata, v & 8'h83);
        end

        // R3/R4 sweep: start code, requested code, ready pattern
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                for (int r = 0; r < 8; r++) begin
                    int exp;
                    src_ready = 3'b111;
                    wr(8'(a));
                    tick();
                    chk("R3", "start src_sel", src_sel, dec(a));
                    src_ready = 3'(r);
                    wr(8'(b));
                    chk("R4", "held at write", src_sel, dec(a));
                    tick();
                    exp = r[dec(b)] ? dec(b) : dec(a);
                    chk("R4", "src_sel", src_sel, exp);
                    tick();
                    chk("R4", "src_sel later", src_sel, exp);
                    chk("R3", "src_active", src_active, 1 << exp);
                end
            end
        end

        // R5-R9 mode sweep
        for (int idle = 0; idle < 2; idle++) begin
            for (int code = 0; code < 4; code++) begin
                for (int rdy = 0; rdy < 2; rdy++) begin
                    logic [7:0] v;
                    v = 8'(idle * 128 + code);
                    src_ready = 3'b111;
                    wr(v);
                    tick();
                    chk("R2", "rdata", reg_rdata, int'(v));
                    pulse_wake();
                    chk_run("R9");
                    pulse_sleep();
                    if (idle == 1) begin
                        chk("R5", "mode", mode, 1);
                        chk("R5", "cpu_en", cpu_clk_en, 0);
                        chk("R5", "per_en", per_clk_en, 1);
                    end else begin
                        chk("R6", "mode", mode, 2);
                        chk("R6", "cpu_en", cpu_clk_en, 0);
                        chk("R6", "per_en", per_clk_en, 0);
                    end
                    pulse_sleep();
                    chk("R9", "mode after extra sleep", mode, idle == 1 ? 1 : 2);
                    if (idle == 1) begin
                        pulse_wake();
                        chk_run("R7");
                    end else begin
                        src_ready = (rdy == 1) ? 3'b111 : (3'b111 & ~(3'(1) << dec(code)));
                        pulse_wake();
                        chk("R8", "waiting mode", mode, 2);
                        chk("R8", "per_en waiting", per_clk_en, 0);
                        if (rdy == 0) begin
                            tick(); tick();
                            chk("R8", "still waiting", mode, 2);
                            src_ready = 3'b111;
                        end
                        tick();
                        chk_run("R8");
                        chk("R8", "src_sel", src_sel, dec(code));
                    end
                end
            end
        end

        // R10 freeze in Sleep, then wake onto the new source
        src_ready = 3'b111;
        wr(8'h00); tick();
        pulse_sleep();
        wr(8'h01); tick(); tick();
        chk("R10", "frozen src_sel", src_sel, 0);
        chk("R10", "mode", mode, 2);
        pulse_wake();
        tick();
        chk("R10", "src after wake", src_sel, 1);
        chk_run("R10");

        // R10 switching continues in Idle
        wr(8'h80); tick();
        pulse_sleep();
        wr(8'h82); tick();
        chk("R10", "idle switch", src_sel, 2);
        chk("R10", "idle mode", mode, 1);
        chk("R11", "cpu_en idle", cpu_clk_en, 0);
        pulse_wake();
        chk_run("R11");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule